// File: doc/BRIEF.md
# Supply-loss reset generator with watchdog

This block drives the single reset line of a chip from two sources. The first is a supply-monitor flag from an analog comparator, which is high while the supply is too low. The block debounces this flag with a cycle-count filter, so short dips do not reset the chip. Once the flag has been high for long enough, reset asserts. Reset stays asserted while the flag is high. After the flag drops, reset is stretched for a fixed number of crystal cycles so that the oscillator can settle before the chip runs.

The second source is a watchdog. It counts pulses from a periodic tick input. A fixed number of ticks forms one time unit, nominally 0.25 s. The timeout is N units, with N from 1 to 8. Software reaches the watchdog through a write strobe with three fields: an enable bit, a self-clearing restart bit and a 3-bit period field. The watchdog is off after any reset. Once software enables it, it stays on until the next chip reset. A timeout passes through the same stretch as a supply dip.

Top module: `brownout_wdt`

## Requirements
- R1: `chip_rst` stays low while `lowv` is high for fewer than `FILT_CYC` consecutive rising edges.
- R2: `chip_rst` rises on the rising edge that samples `lowv` high for the `FILT_CYC`-th consecutive time. It then stays high for as long as `lowv` stays high.
- R3: After the first edge that samples `lowv` low again, `chip_rst` stays high for exactly `HOLD_CYC` cycles. It falls on the `HOLD_CYC`-th edge after that sample.
- R4: `chip_rst` is high while `por_n` is low. It falls on the `HOLD_CYC`-th rising edge after `por_n` goes high.
- R5: After any reset the watchdog is disabled, and no number of ticks causes a reset. A write with `cfg_en`=0 does not turn off a running watchdog.
- R6: Take a write with `cfg_en`=1 and `cfg_period`=v, with v from 0 to 7. `chip_rst` then rises on the edge that samples the (v+1)*`TICKS_PER_UNIT`-th tick after that write. Every write loads `cfg_period`, and ticks count only while the watchdog is enabled.
- R7: A write with `cfg_clr`=1 restarts the tick and unit counts from zero. A full period must then elapse from that write before a timeout.
- R8: A watchdog timeout holds `chip_rst` high for `HOLD_CYC` cycles, as in R3. It also clears the enable, so further ticks cause no reset until software enables the watchdog again.
- R9: Writes made while `chip_rst` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| lowv | input | 1 | Supply-low flag from the comparator, high while the supply is low |
| tick | input | 1 | Single-cycle pulse from the periodic time base |
| cfg_we | input | 1 | Write strobe for the control fields |
| cfg_en | input | 1 | Enable bit; writing 1 turns the watchdog on |
| cfg_clr | input | 1 | Restart strobe; writing 1 zeroes the count |
| cfg_period | input | 3 | Timeout selector v; N = v + 1 units |
| chip_rst | output | 1 | Chip reset, active high |

## Verification
The bench sweeps supply-flag pulses of every length up to the filter limit. It checks the cycle just before the filter trips and the cycle it trips, which exposes a filter that is off by one or that leaks glitches. Every stretch is measured to the exact cycle after a supply dip, a power-on and a timeout, so a hold counter that is off by one shows up as 143 or 145. All eight period codes are swept, with the expected tick count computed as (v+1) units. A design that maps the code as N=v, or that counts the enabling write's cycle as a tick, fires one unit or one tick early. Restarting mid-period, writing the enable bit as 0, and writing during reset check for a count that is not zeroed, an enable that clears, and state that is updated while the chip is in reset.

// File: rtl/brownout_wdt.sv
module brownout_wdt #(
  parameter int FILT_CYC       = 64,
  parameter int HOLD_CYC       = 144,
  parameter int TICKS_PER_UNIT = 250,
  parameter int PER_W          = 3
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             lowv,
  input  logic             tick,
  input  logic             cfg_we,
  input  logic             cfg_en,
  input  logic             cfg_clr,
  input  logic [PER_W-1:0] cfg_period,
  output logic             chip_rst
);
  localparam int FW = $clog2(FILT_CYC + 1);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int TW = $clog2(TICKS_PER_UNIT + 1);
  localparam int UW = PER_W + 1;

  typedef enum logic [1:0] {S_RUN = 2'd0, S_LOW = 2'd1, S_HOLD = 2'd2} st_t;

  st_t             state;
  logic [FW-1:0]   flt;
  logic [HW-1:0]   hcnt;
  logic            wd_en;
  logic [PER_W-1:0] wd_per;
  logic [TW-1:0]   tdiv;
  logic [UW-1:0]   wd_units;

  wire run   = (state == S_RUN);
  wire trip  = lowv && (flt == FW'(FILT_CYC - 1));
  wire restart = cfg_we && cfg_clr;
  wire unit_end = tick && (tdiv == TW'(TICKS_PER_UNIT - 1));
  wire wd_ovf = run && wd_en && !restart && unit_end && (wd_units >= {1'b0, wd_per});

  assign chip_rst = !run;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                           flt <= '0;
    else if (!lowv)                       flt <= '0;
    else if (flt != FW'(FILT_CYC - 1))    flt <= flt + 1'b1;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      state <= S_HOLD;
      hcnt  <= '0;
    end else begin
      case (state)
        S_RUN:
          if (trip) state <= S_LOW;
          else if (wd_ovf) begin
            state <= S_HOLD;
            hcnt  <= '0;
          end
        S_LOW:
          if (!lowv) begin
            state <= S_HOLD;
            hcnt  <= '0;
          end
        default:
          if (trip) state <= S_LOW;
          else if (hcnt == HW'(HOLD_CYC - 1)) state <= S_RUN;
          else hcnt <= hcnt + 1'b1;
      endcase
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      wd_en    <= 1'b0;
      wd_per   <= '1;
      tdiv     <= '0;
      wd_units <= '0;
    end else if (!run) begin
      wd_en    <= 1'b0;
      wd_per   <= '1;
      tdiv     <= '0;
      wd_units <= '0;
    end else begin
      if (cfg_we) begin
        if (cfg_en) wd_en <= 1'b1;
        wd_per <= cfg_period;
      end
      if (restart) begin
        tdiv     <= '0;
        wd_units <= '0;
      end else if (wd_en && tick) begin
        if (unit_end) begin
          tdiv     <= '0;
          wd_units <= wd_units + 1'b1;
        end else begin
          tdiv <= tdiv + 1'b1;
        end
      end
    end
endmodule

// File: rtl/brownout_wdt_chk.sv
module brownout_wdt_chk #(
  parameter int FILT_CYC = 64,
  parameter int HOLD_CYC = 144,
  parameter int PER_W    = 3
) (
  input logic             clk,
  input logic             por_n,
  input logic             lowv,
  input logic             cfg_we,
  input logic             cfg_clr,
  input logic             chip_rst,
  input logic [1:0]       state,
  input logic             wd_en,
  input logic [PER_W:0]   units
);
  int lvc;
  int hc;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) lvc <= 0;
    else if (!lowv) lvc <= 0;
    else if (lvc < FILT_CYC) lvc <= lvc + 1;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) hc <= 0;
    else if (state == 2'd2) hc <= hc + 1;
    else hc <= 0;

  assert_filter_R1: assert property (@(posedge clk) disable iff (!por_n)
    (state == 2'd1) |-> (lvc >= FILT_CYC));

  assert_release_R3: assert property (@(posedge clk) disable iff (!por_n)
    $fell(chip_rst) |-> (hc == HOLD_CYC));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_we && cfg_clr && !chip_rst) |=> (units == '0));

  assert_units_bound_R6: assert property (@(posedge clk) disable iff (!por_n)
    (!chip_rst && wd_en) |-> (int'(units) < (1 << PER_W)));

  assert_en_drop_R8: assert property (@(posedge clk) disable iff (!por_n)
    $rose(chip_rst) |=> !wd_en);
endmodule

bind brownout_wdt brownout_wdt_chk #(.FILT_CYC(FILT_CYC), .HOLD_CYC(HOLD_CYC), .PER_W(PER_W)) u_chk (
  .clk(clk), .por_n(por_n), .lowv(lowv), .cfg_we(cfg_we), .cfg_clr(cfg_clr),
  .chip_rst(chip_rst), .state(state), .wd_en(wd_en), .units(wd_units)
);

// File: tb/brownout_wdt_test.sv
`timescale 1ns/1ps
module brownout_wdt_test;
  localparam int FILT = 4;
  localparam int HOLD = 144;
  localparam int TPU  = 3;

  logic clk = 0, por_n = 0, lowv = 0, tick = 0;
  logic cfg_we = 0, cfg_en = 0, cfg_clr = 0;
  logic [2:0] cfg_period = 0;
  logic chip_rst;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  brownout_wdt #(.FILT_CYC(FILT), .HOLD_CYC(HOLD), .TICKS_PER_UNIT(TPU), .PER_W(3)) uut (
    .clk(clk), .por_n(por_n), .lowv(lowv), .tick(tick), .cfg_we(cfg_we),
    .cfg_en(cfg_en), .cfg_clr(cfg_clr), .cfg_period(cfg_period), .chip_rst(chip_rst)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit en, input bit clr, input logic [2:0] per);
    cfg_we = 1; cfg_en = en; cfg_clr = clr; cfg_period = per;
    @(negedge clk);
    cfg_we = 0; cfg_en = 0; cfg_clr = 0;
  endtask

  task automatic pulse();
    tick = 1;
    @(negedge clk);
    tick = 0;
  endtask

  task automatic count_high(output int n);
    n = 0;
    while (chip_rst && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(chip_rst === 1'b1, "R4 reset during por", chip_rst, 1);
    por_n = 1;
    @(negedge clk);
    count_high(n);
    chk(n == HOLD - 1, "R4 stretch after por", n, HOLD - 1);

    for (int len = 1; len < FILT; len++) begin
      lowv = 1;
      repeat (len) @(negedge clk);
      lowv = 0;
      repeat (FILT + 2) @(negedge clk);
      chk(chip_rst === 1'b0, "R1 glitch ignored", chip_rst, 0);
    end

    lowv = 1;
    repeat (FILT - 1) @(negedge clk);
    chk(chip_rst === 1'b0, "R1 one short of filter", chip_rst, 0);
    @(negedge clk);
    chk(chip_rst === 1'b1, "R2 trip at filter", chip_rst, 1);
    repeat (20) @(negedge clk);
    chk(chip_rst === 1'b1, "R2 held while low", chip_rst, 1);
    lowv = 0;
    @(negedge clk);
    count_high(n);
    chk(n == HOLD, "R3 stretch after recovery", n, HOLD);

    for (int i = 0; i < 8 * TPU * 2 + 4; i++) pulse();
    chk(chip_rst === 1'b0, "R5 disabled after reset", chip_rst, 0);

    for (int v = 0; v < 8; v++) begin
      int t;
      t = (v + 1) * TPU;
      wr(1'b1, 1'b0, 3'(v));
      for (int i = 0; i < t - 1; i++) pulse();
      chk(chip_rst === 1'b0, $sformatf("R6 no reset before tick %0d v=%0d", t, v), chip_rst, 0);
      pulse();
      chk(chip_rst === 1'b1, $sformatf("R6 reset at tick %0d v=%0d", t, v), chip_rst, 1);
      count_high(n);
      chk(n == HOLD, "R8 stretch after timeout", n, HOLD);
      for (int i = 0; i < t + 2; i++) pulse();
      chk(chip_rst === 1'b0, "R8 enable cleared by timeout", chip_rst, 0);
    end

    wr(1'b1, 1'b0, 3'd1);
    repeat (5) pulse();
    wr(1'b0, 1'b1, 3'd1);
    repeat (5) pulse();
    chk(chip_rst === 1'b0, "R7 restart delays timeout", chip_rst, 0);
    pulse();
    chk(chip_rst === 1'b1, "R7 full period after restart", chip_rst, 1);
    count_high(n);

    wr(1'b1, 1'b0, 3'd0);
    wr(1'b0, 1'b0, 3'd0);
    repeat (TPU - 1) pulse();
    chk(chip_rst === 1'b0, "R5 still counting", chip_rst, 0);
    pulse();
    chk(chip_rst === 1'b1, "R5 enable sticks after write of 0", chip_rst, 1);
    count_high(n);

    lowv = 1;
    repeat (FILT + 2) @(negedge clk);
    lowv = 0;
    @(negedge clk);
    wr(1'b1, 1'b0, 3'd0);
    count_high(n);
    chk(n == HOLD - 1, "R3 stretch with write inside", n, HOLD - 1);
    repeat (10) pulse();
    chk(chip_rst === 1'b0, "R9 write during reset ignored", chip_rst, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule